// File: doc/BRIEF.md
# Prescaled Compare Timer

The block is a counter timer that runs from a base tick enable. When the timer is running, a power-of-two prescaler divides the base tick. Each prescaled step adds one to the counter. The counter wraps at a width chosen from four modes. Four compare channels each hold a value. When the counter steps onto a channel's value, that channel's event flag is set. The flag stays set until software clears it.

Software uses a simple word-addressed register bus. Writing 1 to the go, halt or zero task words starts the timer, stops it, or resets it. The width mode and the prescaler take new values only while the timer is stopped. Compare values can be written at any time. A compare value the counter has already passed fires only after the counter wraps and climbs back to it.

Top module: `cmp_timer`

## Requirements
- R1: After reset the timer is stopped, every event flag reads 0, the width mode reads 0 and the prescaler reads 0.
- R2: A write with bit 0 set to word 0 starts the timer, to word 1 stops it, and to word 2 zeroes it. A write to a task word with bit 0 clear does nothing. A stopped timer holds its count.
- R3: While running, the counter advances by one for every 2^P base ticks, where P is the prescaler in word 4. A write of a value above 9 stores 9.
- R4: Width mode in word 3, bits [1:0]: code 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. After all ones the counter wraps to 0.
- R5: Compare value i is in word 8+i. Event i is set on the step where the counter becomes equal to the low width bits of that value. A value the counter has already passed fires only after a wrap.
- R6: Event i is bit 0 of word 12+i and stays 1 once set. Writing 0 clears it. Writing 1 has no effect.
- R7: Writes to the width mode or prescaler while the timer runs are ignored.
- R8: The zero task sets the count to 0 and restarts the prescaler phase. It raises no event and is allowed while running.
- R9: A read strobe returns the addressed word on bus_rdata_o, with bus_rvalid_o high, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick enable |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |

## Verification
The count cannot be read directly, so a wrong count, prescaler phase or width mask shows up only as an event that fires early, late or never. The bench therefore reads each event one base tick before its expected step and again just after it, which pins errors to the exact step. A flag that is wrongly cleared, or wrongly set by a zero task, is seen at the next read of that flag. A width or prescaler write that leaks through while running shows in the next readback of that word.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned REG_AW = 4;

    typedef enum logic [1:0] {
        WM_16 = 2'd0,
        WM_08 = 2'd1,
        WM_24 = 2'd2,
        WM_32 = 2'd3
    } width_mode_e;

    localparam logic [REG_AW-1:0] A_GO      = 4'd0;
    localparam logic [REG_AW-1:0] A_HALT    = 4'd1;
    localparam logic [REG_AW-1:0] A_ZERO    = 4'd2;
    localparam logic [REG_AW-1:0] A_WIDTH   = 4'd3;
    localparam logic [REG_AW-1:0] A_PRESC   = 4'd4;
    localparam logic [REG_AW-1:0] A_CC_BASE = 4'd8;
    localparam logic [REG_AW-1:0] A_EV_BASE = 4'd12;

    // number of counter bits selected by a width mode
    function automatic int mode_bits(width_mode_e m);
        case (m)
            WM_08:   return 8;
            WM_24:   return 24;
            WM_32:   return 32;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
    parameter int unsigned PRESC_MAX = 9,
    parameter int unsigned SEL_W     = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] presc_i,
    output logic             step_o
);
    localparam int unsigned PW = (PRESC_MAX > 0) ? PRESC_MAX : 1;

    typedef struct packed {
        logic [PW-1:0] div;
    } presc_state_t;

    presc_state_t ps_d, ps_q;
    logic [PW-1:0] mask;

    always_comb begin
        for (int b = 0; b < int'(PW); b++) begin
            mask[b] = (b < int'(presc_i));
        end
        ps_d   = ps_q;
        step_o = run_i && tick_i && !restart_i && ((ps_q.div & mask) == mask);
        if (restart_i) begin
            ps_d.div = '0;
        end else if (run_i && tick_i) begin
            ps_d.div = ps_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ps_q <= '0;
        else         ps_q <= ps_d;
    end

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CC = 4
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             step_i,
    input  logic                             clear_i,
    input  logic [CNT_W-1:0]                 wmask_i,
    input  logic [NUM_CC-1:0][CNT_W-1:0]     cc_i,
    output logic [CNT_W-1:0]                 count_o,
    output logic [NUM_CC-1:0]                hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt  = (cs_q.count + 1'b1) & wmask_i;
        cs_d = cs_q;
        if (clear_i)     cs_d.count = '0;
        else if (step_i) cs_d.count = nxt;
    end

    // one equality comparator per compare channel
    for (genvar g = 0; g < int'(NUM_CC); g++) begin : g_cmp
        assign hit_o[g] = step_i && !clear_i && (nxt == (cc_i[g] & wmask_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q <= '0;
        else         cs_q <= cs_d;
    end

    assign count_o = cs_q.count;

endmodule

// File: rtl/cmp_timer_events.sv
module cmp_timer_events #(
    parameter int unsigned NUM_CC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CC-1:0] set_i,
    input  logic [NUM_CC-1:0] clr_i,
    output logic [NUM_CC-1:0] ev_o
);
    typedef struct packed {
        logic [NUM_CC-1:0] flag;
    } ev_state_t;

    ev_state_t es_d, es_q;

    // a set on the same cycle as a clear wins, so no hit is lost
    always_comb begin
        es_d      = es_q;
        es_d.flag = (es_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) es_q <= '0;
        else         es_q <= es_d;
    end

    assign ev_o = es_q.flag;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_CC    = 4,
    parameter int unsigned PRESC_MAX = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [3:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o
);
    localparam int unsigned SEL_W = $clog2(PRESC_MAX + 1);

    typedef struct packed {
        logic                         run;
        width_mode_e                  mode;
        logic [SEL_W-1:0]             presc;
        logic [NUM_CC-1:0][CNT_W-1:0] cc;
        logic [DATA_W-1:0]            rdata;
        logic                         rvalid;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              go_req, halt_req, zero_req;
    logic [NUM_CC-1:0] ev_clr;
    logic [NUM_CC-1:0] hit;
    logic [NUM_CC-1:0] ev;
    logic [CNT_W-1:0]  wmask;
    logic [CNT_W-1:0]  count_w;
    logic              step;
    logic              run_w;
    logic [1:0]        mode_w;
    logic [SEL_W-1:0]  presc_w;

    assign run_w   = st_q.run;
    assign mode_w  = st_q.mode;
    assign presc_w = st_q.presc;

    // width mask from the active mode
    always_comb begin
        for (int b = 0; b < int'(CNT_W); b++) begin
            wmask[b] = (b < mode_bits(st_q.mode));
        end
    end

    // register decode and next state
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd_i;

        go_req   = bus_wr_i && (bus_addr_i == A_GO)   && bus_wdata_i[0];
        halt_req = bus_wr_i && (bus_addr_i == A_HALT) && bus_wdata_i[0];
        zero_req = bus_wr_i && (bus_addr_i == A_ZERO) && bus_wdata_i[0];

        if (go_req)   st_d.run = 1'b1;
        if (halt_req) st_d.run = 1'b0;

        if (bus_wr_i && !st_q.run) begin
            if (bus_addr_i == A_WIDTH) begin
                st_d.mode = width_mode_e'(bus_wdata_i[1:0]);
            end
            if (bus_addr_i == A_PRESC) begin
                if (bus_wdata_i > DATA_W'(PRESC_MAX)) st_d.presc = SEL_W'(PRESC_MAX);
                else                                   st_d.presc = bus_wdata_i[SEL_W-1:0];
            end
        end

        for (int i = 0; i < int'(NUM_CC); i++) begin
            if (bus_wr_i && (bus_addr_i == A_CC_BASE + REG_AW'(i))) begin
                st_d.cc[i] = bus_wdata_i[CNT_W-1:0];
            end
            ev_clr[i] = bus_wr_i && (bus_addr_i == A_EV_BASE + REG_AW'(i)) && !bus_wdata_i[0];
        end

        if (bus_rd_i) begin
            st_d.rdata = '0;
            if (bus_addr_i == A_WIDTH) st_d.rdata[1:0]       = st_q.mode;
            if (bus_addr_i == A_PRESC) st_d.rdata[SEL_W-1:0] = st_q.presc;
            for (int i = 0; i < int'(NUM_CC); i++) begin
                if (bus_addr_i == A_CC_BASE + REG_AW'(i)) st_d.rdata[CNT_W-1:0] = st_q.cc[i];
                if (bus_addr_i == A_EV_BASE + REG_AW'(i)) st_d.rdata[0]         = ev[i];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    cmp_timer_presc #(
        .PRESC_MAX (PRESC_MAX),
        .SEL_W     (SEL_W)
    ) presc_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (st_q.run),
        .tick_i    (tick_i),
        .restart_i (zero_req),
        .presc_i   (st_q.presc),
        .step_o    (step)
    );

    cmp_timer_count #(
        .CNT_W  (CNT_W),
        .NUM_CC (NUM_CC)
    ) count_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step),
        .clear_i (zero_req),
        .wmask_i (wmask),
        .cc_i    (st_q.cc),
        .count_o (count_w),
        .hit_o   (hit)
    );

    cmp_timer_events #(
        .NUM_CC (NUM_CC)
    ) events_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (hit),
        .clr_i  (ev_clr),
        .ev_o   (ev)
    );

    assign bus_rdata_o  = st_q.rdata;
    assign bus_rvalid_o = st_q.rvalid;

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_CC    = 4,
    parameter int unsigned PRESC_MAX = 9,
    parameter int unsigned SEL_W     = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              run_i,
    input logic [1:0]        mode_i,
    input logic [SEL_W-1:0]  presc_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [CNT_W-1:0]  wmask_i,
    input logic              step_i,
    input logic              zero_i,
    input logic [NUM_CC-1:0] ev_i,
    input logic [NUM_CC-1:0] ev_clr_i
);
    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    // R2
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && ($past(run_i) == 1'b0) && ($past(zero_i) == 1'b0)
        |-> count_i == $past(count_i));

    // R4
    in_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(step_i) |-> (count_i & ~$past(wmask_i)) == '0);

    // R5
    ev_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && ((ev_i & ~$past(ev_i)) != '0) |-> $past(step_i) && !$past(zero_i));

    // R6
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> ($past(ev_i) & ~$past(ev_clr_i) & ~ev_i) == '0);

    // R7
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(run_i) |-> (mode_i == $past(mode_i)) && (presc_i == $past(presc_i)));

    // R3
    presc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(presc_i) <= int'(PRESC_MAX));

endmodule

bind cmp_timer cmp_timer_chk #(
    .CNT_W     (CNT_W),
    .NUM_CC    (NUM_CC),
    .PRESC_MAX (PRESC_MAX),
    .SEL_W     (SEL_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .mode_i   (mode_w),
    .presc_i  (presc_w),
    .count_i  (count_w),
    .wmask_i  (wmask),
    .step_i   (step),
    .zero_i   (zero_req),
    .ev_i     (ev),
    .ev_clr_i (ev_clr)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    cmp_timer dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid)
    );

    // monitor: compares each returned read with the head of the scoreboard
    always @(negedge clk) begin
        if (rvalid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected read data %0h, expected none", rdata);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s actual %0h expected %0h", t, rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic expect_read(input logic [3:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_events();
        for (int i = 0; i < 4; i++) bus_write(4'(12 + i), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog expired, actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 4; i++) expect_read(4'(12 + i), 32'd0, "R1 event after reset");
        expect_read(4'd3, 32'd0, "R1 width mode after reset");
        expect_read(4'd4, 32'd0, "R1 prescaler after reset");
        ticks(5);
        expect_read(4'd12, 32'd0, "R1 no event before start");

        // R5: compare sweep, 16-bit, prescaler 0
        bus_write(4'd8, 32'd2);
        bus_write(4'd9, 32'd162);
        bus_write(4'd10, 32'd480);
        bus_write(4'd0, 32'd1);           // R2 go
        ticks(160);
        expect_read(4'd12, 32'd1, "R5 cc0 fired in first stretch");
        expect_read(4'd13, 32'd0, "R5 cc1 not yet");
        ticks(160);
        expect_read(4'd13, 32'd1, "R5 cc1 fired in second stretch");
        ticks(159);
        expect_read(4'd14, 32'd0, "R5 cc2 one step early");
        ticks(1);
        expect_read(4'd14, 32'd1, "R5 cc2 exact step");

        // R5/R4: value already passed fires only after 16-bit wrap
        bus_write(4'd11, 32'd114);
        ticks(65055 + 1 + 113);
        expect_read(4'd15, 32'd0, "R4 cc3 one step before after wrap");
        ticks(1);
        expect_read(4'd15, 32'd1, "R4 cc3 fired after wrap");

        // R6: clear and write-1 ignore
        clear_events();
        for (int i = 0; i < 4; i++) expect_read(4'(12 + i), 32'd0, "R6 cleared by write 0");
        bus_write(4'd12, 32'd1);
        expect_read(4'd12, 32'd0, "R6 write 1 has no effect");

        // R2: stop holds count, ignore task write with bit0 clear
        bus_write(4'd8, 32'd120);         // count is 114
        bus_write(4'd1, 32'd1);
        ticks(10);
        bus_write(4'd0, 32'd0);           // not a trigger
        ticks(10);
        expect_read(4'd12, 32'd0, "R2 stopped counter holds");
        bus_write(4'd0, 32'd1);
        ticks(5);
        expect_read(4'd12, 32'd0, "R2 resumes from held count");
        ticks(1);
        expect_read(4'd12, 32'd1, "R2 resumed count reaches 120");

        // R7: width write while running ignored
        bus_write(4'd3, 32'd1);
        expect_read(4'd3, 32'd0, "R7 width write ignored while running");
        bus_write(4'd4, 32'd3);
        expect_read(4'd4, 32'd0, "R7 prescaler write ignored while running");

        // R4: 8-bit mode with masked compare values
        bus_write(4'd1, 32'd1);
        bus_write(4'd3, 32'd1);
        expect_read(4'd3, 32'd1, "R4 width mode 8 accepted while stopped");
        bus_write(4'd2, 32'd1);
        clear_events();
        bus_write(4'd9, 32'd3);
        bus_write(4'd10, 32'h102);
        bus_write(4'd0, 32'd1);
        ticks(2);
        expect_read(4'd13, 32'd0, "R8 count restarted from zero");
        expect_read(4'd14, 32'd1, "R5 low width bits compared");
        ticks(1);
        expect_read(4'd13, 32'd1, "R8 cc1 at 3 after zero");
        bus_write(4'd14, 32'd0);
        ticks(254);
        expect_read(4'd14, 32'd0, "R4 8-bit wrap not yet at 2");
        ticks(1);
        expect_read(4'd14, 32'd1, "R4 8-bit wrap reaches 2");

        // R3: prescaler clamp and divide by 4
        bus_write(4'd1, 32'd1);
        bus_write(4'd3, 32'd0);
        bus_write(4'd4, 32'd12);
        expect_read(4'd4, 32'd9, "R3 prescaler clamps to 9");
        bus_write(4'd4, 32'd2);
        expect_read(4'd4, 32'd2, "R3 prescaler set to 2");
        bus_write(4'd2, 32'd1);
        clear_events();
        bus_write(4'd8, 32'd3);
        bus_write(4'd0, 32'd1);
        ticks(11);
        expect_read(4'd12, 32'd0, "R3 eleven ticks give two steps");
        ticks(1);
        expect_read(4'd12, 32'd1, "R3 twelve ticks give three steps");

        // R8: zero while running, no event raised by zeroing
        ticks(5);
        bus_write(4'd12, 32'd0);
        bus_write(4'd8, 32'd0);
        bus_write(4'd2, 32'd1);
        expect_read(4'd12, 32'd0, "R8 zeroing raises no event");
        bus_write(4'd8, 32'd3);
        ticks(11);
        expect_read(4'd12, 32'd0, "R8 prescaler phase restarted");
        ticks(1);
        expect_read(4'd12, 32'd1, "R8 step after zero while running");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9 reads outstanding actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule